// File: doc/BRIEF.md
# One-Hot Parallel Multiplexer

This block is a purely combinational selector. A packed candidate bus carries `LINES` words of `DATA_W` bits each, and a select vector of `LINES` bits names which word reaches the output. When no select line is raised, a separate fallback word is passed through instead. The select vector is meant to be one-hot. It typically comes from a decoded case statement or a parallel arbiter grant.

A build-time policy parameter fixes what happens when the select vector carries more than one raised line. Under the guarded policy (`MULTI_DEFAULT`), the fallback word is forced onto the output. Under the relaxed policy (`MULTI_UNSPEC`), the output carries no promise. A four-state simulation shows it as all-X, so that misuse is visible. The block holds no state and has no clock.

Top module: `onehot_select_mux`

## Requirements
- R1: With every select line low, the output equals the fallback word, under either policy.
- R2: With only select line n high, the output equals candidate word n, which is bits `n*DATA_W + DATA_W-1` down to `n*DATA_W` of the candidate bus. Word 0 sits in the least significant bits.
- R3: Under the guarded policy (`MULTI_DEFAULT`), a select vector with two or more lines high yields the fallback word.
- R4: Under the relaxed policy (`MULTI_UNSPEC`), a select vector with two or more lines high gives an unspecified output (all-X in four-state simulation). Nothing from that input carries over: the next zero-hot or one-hot select yields the R1 or R2 value at once.
- R5: While exactly one line is high, the fallback word has no effect on the output.
- R6: Candidate words whose select line is low have no effect on the output.
- R7: The output depends only on the present inputs, with no register on the path, so it settles in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fallbackWord | input | DATA_W | Word passed through when no line, or under the guarded policy several lines, are high |
| candBus | input | DATA_W*LINES | Packed candidate words; word n at bits n*DATA_W upward |
| selLines | input | LINES | One-hot select; bit n picks candidate word n |
| muxOut | output | DATA_W | Selected word |

## Verification
Every result is due in the same cycle as its stimulus, because the path from any input to `muxOut` has no register. The bench changes inputs on the falling clock edge and samples `muxOut` two nanoseconds later, well before the next rising edge. As a result, each check sees the value settled from that cycle's inputs alone. The relaxed-policy case checks only that a following legal select recovers its value at once, since the multi-hot value itself is unspecified.

// File: rtl/onehot_select_pkg.sv
package onehot_select_pkg;

  // Policy for a select vector with more than one raised line
  typedef enum logic {
    MULTI_UNSPEC  = 1'b0,
    MULTI_DEFAULT = 1'b1
  } multiPolicy_e;

  // Strobes from the select decoder to the data path
  typedef struct packed {
    logic useFallback;
    logic markUnknown;
  } selStrobes_t;

endpackage

// File: rtl/onehot_select_ctrl.sv
module onehot_select_ctrl
  import onehot_select_pkg::*;
#(
  parameter int           LINES  = 5,
  parameter multiPolicy_e POLICY = MULTI_DEFAULT
) (
  input  logic [LINES-1:0] selLines,
  output selStrobes_t      strobes,
  output logic [LINES-1:0] laneEn
);

  logic noneHot;
  logic multiHot;

  always_comb begin
    noneHot  = (selLines == '0);
    // Clearing the lowest raised bit leaves something only if two or more were set
    multiHot = ((selLines & (selLines - LINES'(1))) != '0);
  end

  generate
    if (POLICY == MULTI_DEFAULT) begin : g_guarded
      always_comb begin
        strobes.useFallback = noneHot | multiHot;
        strobes.markUnknown = 1'b0;
      end
    end else begin : g_relaxed
      always_comb begin
        strobes.useFallback = noneHot;
        strobes.markUnknown = multiHot;
      end
    end
  endgenerate

  assign laneEn = strobes.useFallback ? '0 : selLines;

endmodule

// File: rtl/onehot_select_dpath.sv
module onehot_select_dpath
  import onehot_select_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINES  = 5
) (
  input  logic [DATA_W-1:0]       fallbackWord,
  input  logic [DATA_W*LINES-1:0] candBus,
  input  logic [LINES-1:0]        laneEn,
  input  selStrobes_t             strobes,
  output logic [DATA_W-1:0]       muxOut
);

  logic [DATA_W-1:0] gatedWord [LINES];
  logic [DATA_W-1:0] orTree;

  // Gate each candidate word with its lane enable
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_lane
      assign gatedWord[g] = candBus[g*DATA_W +: DATA_W] & {DATA_W{laneEn[g]}};
    end
  endgenerate

  always_comb begin
    orTree = '0;
    for (int i = 0; i < LINES; i++) begin
      orTree = orTree | gatedWord[i];
    end
  end

  always_comb begin
    if (strobes.useFallback) begin
      muxOut = fallbackWord;
    end else if (strobes.markUnknown) begin
      muxOut = 'x;
    end else begin
      muxOut = orTree;
    end
  end

endmodule

// File: rtl/onehot_select_mux.sv
module onehot_select_mux
  import onehot_select_pkg::*;
#(
  parameter int           DATA_W = 8,
  parameter int           LINES  = 5,
  parameter multiPolicy_e POLICY = MULTI_DEFAULT
) (
  input  logic [DATA_W-1:0]       fallbackWord,
  input  logic [DATA_W*LINES-1:0] candBus,
  input  logic [LINES-1:0]        selLines,
  output logic [DATA_W-1:0]       muxOut
);

  selStrobes_t      strobes;
  logic [LINES-1:0] laneEn;

  onehot_select_ctrl #(
    .LINES (LINES),
    .POLICY(POLICY)
  ) ctrl_i (
    .selLines(selLines),
    .strobes (strobes),
    .laneEn  (laneEn)
  );

  onehot_select_dpath #(
    .DATA_W(DATA_W),
    .LINES (LINES)
  ) dpath_i (
    .fallbackWord(fallbackWord),
    .candBus     (candBus),
    .laneEn      (laneEn),
    .strobes     (strobes),
    .muxOut      (muxOut)
  );

endmodule

// File: rtl/onehot_select_chk.sv
module onehot_select_chk
  import onehot_select_pkg::*;
#(
  parameter int           DATA_W = 8,
  parameter int           LINES  = 5,
  parameter multiPolicy_e POLICY = MULTI_DEFAULT
) (
  input logic [DATA_W-1:0]       fallbackWord,
  input logic [DATA_W*LINES-1:0] candBus,
  input logic [LINES-1:0]        selLines,
  input logic [DATA_W-1:0]       muxOut
);

  logic [DATA_W-1:0] pickedWord;

  always_comb begin
    pickedWord = '0;
    for (int i = 0; i < LINES; i++) begin
      if (selLines[i]) pickedWord = candBus[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (!$isunknown({selLines, fallbackWord, candBus})) begin
      // R1
      zero_hot_fallback_chk: assert (selLines != '0 || muxOut == fallbackWord)
        else $error("zero-hot select did not pass the fallback word");
      // R2
      one_hot_pick_chk: assert ($countones(selLines) != 1 || muxOut == pickedWord)
        else $error("one-hot select did not pass its candidate word");
      // R3
      guarded_multi_chk: assert (POLICY != MULTI_DEFAULT || $countones(selLines) < 2
                                 || muxOut == fallbackWord)
        else $error("guarded policy let a multi-hot select through");
      // R7
      known_out_chk: assert (!$onehot0(selLines) || !$isunknown(muxOut))
        else $error("legal select produced an unknown output");
    end
  end

endmodule

bind onehot_select_mux onehot_select_chk #(
  .DATA_W(DATA_W),
  .LINES (LINES),
  .POLICY(POLICY)
) chk_i (
  .fallbackWord(fallbackWord),
  .candBus     (candBus),
  .selLines    (selLines),
  .muxOut      (muxOut)
);

// File: tb/onehot_select_mux_tb_top.sv
`timescale 1ns/1ps
module onehot_select_mux_tb_top;
  import onehot_select_pkg::*;

  localparam int DATA_W = 8;
  localparam int LINES  = 5;
  localparam int BUS_W  = DATA_W * LINES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [DATA_W-1:0] fallbackWord;
  logic [BUS_W-1:0]  candBus;
  logic [LINES-1:0]  selLines;
  logic [DATA_W-1:0] guardOut;
  logic [DATA_W-1:0] relaxOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  onehot_select_mux #(.DATA_W(DATA_W), .LINES(LINES), .POLICY(MULTI_DEFAULT)) dut_i (
    .fallbackWord(fallbackWord), .candBus(candBus), .selLines(selLines), .muxOut(guardOut));

  onehot_select_mux #(.DATA_W(DATA_W), .LINES(LINES), .POLICY(MULTI_UNSPEC)) dut_relax_i (
    .fallbackWord(fallbackWord), .candBus(candBus), .selLines(selLines), .muxOut(relaxOut));

  function automatic logic [DATA_W-1:0] wordOf(input logic [BUS_W-1:0] bus, input int n);
    return DATA_W'(bus >> (n * DATA_W));
  endfunction

  task automatic checkVal(input string req, input logic [DATA_W-1:0] act,
                          input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply on the falling edge, sample 2 ns later (same cycle, combinational path)
  task automatic apply(input logic [DATA_W-1:0] fb, input logic [BUS_W-1:0] cb,
                       input logic [LINES-1:0] sl);
    @(negedge clk);
    fallbackWord = fb;
    candBus      = cb;
    selLines     = sl;
    #2;
  endtask

  function automatic logic [BUS_W-1:0] randBus();
    logic [BUS_W-1:0] b;
    for (int i = 0; i < BUS_W; i += 32) b[i +: 32] = $urandom();
    return b;
  endfunction

  task automatic testResetState();
    apply('0, '0, '0);
    checkVal("R1 reset-state guarded", guardOut, '0);
    checkVal("R1 reset-state relaxed", relaxOut, '0);
  endtask

  task automatic testZeroHot();
    for (int k = 0; k < 4; k++) begin
      logic [DATA_W-1:0] fb = DATA_W'($urandom());
      apply(fb, randBus(), '0);
      checkVal("R1 zero-hot guarded", guardOut, fb);
      checkVal("R1 zero-hot relaxed", relaxOut, fb);
    end
  endtask

  task automatic testEveryOneHot();
    for (int n = 0; n < LINES; n++) begin
      logic [BUS_W-1:0] cb = randBus();
      apply(DATA_W'($urandom()), cb, LINES'(1) << n);
      checkVal("R2 one-hot guarded", guardOut, wordOf(cb, n));
      checkVal("R2 one-hot relaxed", relaxOut, wordOf(cb, n));
    end
    // Word 0 in the least significant bits: distinct marker per word
    apply(8'hEE, {8'h44, 8'h33, 8'h22, 8'h11, 8'h00}, 5'b00001);
    checkVal("R2 word0-lsb", guardOut, 8'h00);
    apply(8'hEE, {8'h44, 8'h33, 8'h22, 8'h11, 8'h00}, 5'b10000);
    checkVal("R2 top-word", guardOut, 8'h44);
  endtask

  task automatic testGuardedMulti();
    for (int k = 0; k < 20; k++) begin
      logic [LINES-1:0] sl = LINES'($urandom());
      logic [DATA_W-1:0] fb = DATA_W'($urandom());
      if ($countones(sl) < 2) sl = sl | LINES'(5'b00011 << (k % (LINES - 1)));
      if ($countones(sl) < 2) sl = 5'b10001;
      apply(fb, randBus(), sl);
      checkVal("R3 guarded multi-hot", guardOut, fb);
    end
    apply(8'h5A, randBus(), '1);
    checkVal("R3 guarded all-hot", guardOut, 8'h5A);
  endtask

  task automatic testRelaxedRecovery();
    logic [BUS_W-1:0] cb = randBus();
    apply(8'h3C, cb, 5'b01010);
    apply(8'h3C, cb, 5'b01000);
    checkVal("R4 relaxed recover one-hot", relaxOut, wordOf(cb, 3));
    apply(8'hC3, cb, '1);
    apply(8'hC3, cb, '0);
    checkVal("R4 relaxed recover zero-hot", relaxOut, 8'hC3);
  endtask

  task automatic testFallbackIgnored();
    logic [BUS_W-1:0] cb = randBus();
    apply(8'h00, cb, 5'b00100);
    checkVal("R5 fallback ignored a", guardOut, wordOf(cb, 2));
    apply(8'hFF, cb, 5'b00100);
    checkVal("R5 fallback ignored b", guardOut, wordOf(cb, 2));
  endtask

  task automatic testOthersIgnored();
    logic [BUS_W-1:0] cb = randBus();
    logic [BUS_W-1:0] mask = {{DATA_W{1'b1}}, {DATA_W{1'b1}}, {DATA_W{1'b0}},
                              {DATA_W{1'b1}}, {DATA_W{1'b1}}};
    apply(8'h77, cb, 5'b00100);
    checkVal("R6 others ignored base", guardOut, wordOf(cb, 2));
    apply(8'h77, cb ^ mask, 5'b00100);
    checkVal("R6 others ignored flipped", guardOut, wordOf(cb, 2));
    checkVal("R6 others ignored relaxed", relaxOut, wordOf(cb, 2));
  endtask

  task automatic testSameCycle();
    logic [BUS_W-1:0] cb = randBus();
    @(negedge clk);
    fallbackWord = 8'h9D;
    candBus = cb;
    selLines = 5'b00010;
    #1;
    checkVal("R7 same-cycle select", guardOut, wordOf(cb, 1));
    selLines = '0;
    #1;
    checkVal("R7 same-cycle fallback", guardOut, 8'h9D);
  endtask

  initial begin
    fallbackWord = '0;
    candBus = '0;
    selLines = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    testResetState();
    testZeroHot();
    testEveryOneHot();
    testGuardedMulti();
    testRelaxedRecovery();
    testFallbackIgnored();
    testOthersIgnored();
    testSameCycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule